// File: doc/BRIEF.md
# Cartridge Sweep Read Sequencer

This controller reads a whole removable disk cartridge in response to one start pulse. It walks every sector address in a fixed nested order and drives a lower-level disk transaction engine through a simple request and done handshake. Whenever the walk reaches a new cylinder, including the first one, it issues a seek to that cylinder. It then issues one read-sector request per sector. Only one request is in flight at a time.

For each errored read, the block reports a one-cycle flag with the linear sector number, so a caller can log it (for example, in a RAM indexed by that number). It also keeps a running count of errored sectors. A mode input selects what a checksum error does: it either halts the sweep with an error status or is tallied and passed over. The final status stays valid until the next start.

Top module: `sweep_seq`

## Requirements
- R1: After reset the block is idle: busy_o, req_o, done_o, err_o and sect_err_o are 0 and err_cnt_o is 0.
- R2: Reads are issued with the sector index innermost (0..11), then the head index (0, 1), then the cylinder index outermost (0..202). The last read is cylinder 202, head 1, sector 11.
- R3: A seek (cmd_o = 0, with cyl_o carrying the target) is issued before the first read of every cylinder, including cylinder 0. Reads use cmd_o = 1.
- R4: A full sweep with no halting error issues exactly 4,872 reads and 203 seeks. It then drops busy_o and sets done_o = 1 and err_o = 0.
- R5: While req_o is high and ack_i is low, req_o, cmd_o and the address stay unchanged. In the cycle after ack_i, req_o is 0, so at most one request is outstanding.
- R6: With halt_on_err_i = 1, a read acknowledged with csum_err_i = 1 ends the sweep. The block then shows err_o = 1 and done_o = 0 and issues no further request.
- R7: With halt_on_err_i = 0, read checksum errors do not stop the sweep. It completes with done_o = 1 and err_o = 0.
- R8: In the cycle after an errored read's ack, sect_err_o is 1 for one cycle and err_idx_o = cylinder*24 + head*12 + sector. err_cnt_o counts the errored reads of the current sweep.
- R9: csum_err_i asserted together with ack_i of a seek is ignored: no halt, no count, no sect_err_o.
- R10: A start pulse while busy_o is 1 is ignored. done_o, err_o and err_cnt_o hold after a sweep until the next start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that starts a sweep when idle |
| halt_on_err_i | input | 1 | 1: a read checksum error halts the sweep |
| req_o | output | 1 | Request to the transaction engine |
| cmd_o | output | 1 | Request type: 0 seek, 1 read sector |
| cyl_o | output | 8 | Cylinder index |
| head_o | output | 1 | Head index |
| sect_o | output | 4 | Sector index |
| ack_i | input | 1 | One-cycle done pulse for the current request |
| csum_err_i | input | 1 | Checksum error, valid with ack_i |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Last sweep covered the whole cartridge |
| err_o | output | 1 | Last sweep halted on a checksum error |
| sect_err_o | output | 1 | One-cycle flag for an errored read |
| err_idx_o | output | 13 | Linear sector number of the flagged read |
| err_cnt_o | output | 13 | Errored reads in the current sweep |

## Verification
A model in the bench follows the nested walk with an engine that acknowledges after a random 0 to 2 cycles. This separates a correct request order from one that merely counts correctly. A full sweep with about 4% random read errors and halting disabled tells whether errors are tallied and skipped rather than stopping the walk. A directed error on read 30, with checksum flags raised on every seek ack, tells whether the halt fires on the right read and only on reads. A directed error on the very last sector tells whether the halt outcome wins over completion. A start pulse injected mid-sweep would show up as an address mismatch if it restarted the walk.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_GAP} st_e;
  localparam logic CMD_SEEK = 1'b0;
  localparam logic CMD_READ = 1'b1;
endpackage

// File: rtl/sweep_addr_walk.sv
module sweep_addr_walk #(
  parameter int N_SECT = 12,
  parameter int N_HEAD = 2,
  parameter int N_CYL  = 203,
  localparam int SECT_W = $clog2(N_SECT),
  localparam int HEAD_W = (N_HEAD > 1) ? $clog2(N_HEAD) : 1,
  localparam int CYL_W  = $clog2(N_CYL),
  localparam int LIN_W  = $clog2(N_SECT * N_HEAD * N_CYL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [CYL_W-1:0]  cyl_o,
  output logic [HEAD_W-1:0] head_o,
  output logic [SECT_W-1:0] sect_o,
  output logic [LIN_W-1:0]  lin_o,
  output logic              cyl_step_o,
  output logic              last_o
);
  logic [CYL_W-1:0]  cyl_q;
  logic [HEAD_W-1:0] head_q;
  logic [SECT_W-1:0] sect_q;
  logic [LIN_W-1:0]  lin_q;
  logic sect_last, head_last, cyl_last;

  assign sect_last = (sect_q == SECT_W'(N_SECT - 1));
  assign head_last = (head_q == HEAD_W'(N_HEAD - 1));
  assign cyl_last  = (cyl_q == CYL_W'(N_CYL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyl_q  <= '0;
      head_q <= '0;
      sect_q <= '0;
      lin_q  <= '0;
    end else if (clr_i) begin
      cyl_q  <= '0;
      head_q <= '0;
      sect_q <= '0;
      lin_q  <= '0;
    end else if (adv_i) begin
      lin_q <= lin_q + LIN_W'(1);
      if (sect_last) begin
        sect_q <= '0;
        if (head_last) begin
          head_q <= '0;
          cyl_q  <= cyl_q + CYL_W'(1);
        end else begin
          head_q <= head_q + HEAD_W'(1);
        end
      end else begin
        sect_q <= sect_q + SECT_W'(1);
      end
    end
  end

  assign cyl_o      = cyl_q;
  assign head_o     = head_q;
  assign sect_o     = sect_q;
  assign lin_o      = lin_q;
  assign cyl_step_o = sect_last & head_last;
  assign last_o     = sect_last & head_last & cyl_last;

  p_sect_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sect_q < SECT_W'(N_SECT));
  p_cyl_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyl_q < CYL_W'(N_CYL));
  p_sect_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !clr_i && sect_last |=> sect_q == '0);
endmodule

// File: rtl/sweep_err_track.sv
module sweep_err_track #(
  parameter int LIN_W = 13,
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [LIN_W-1:0] idx_i,
  output logic             flag_o,
  output logic [LIN_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      idx_o  <= '0;
      cnt_o  <= '0;
    end else begin
      flag_o <= hit_i;
      if (hit_i) idx_o <= idx_i;
      if (clr_i) cnt_o <= '0;
      else if (hit_i) cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  p_err_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> cnt_o == $past(cnt_o) + CNT_W'(1));
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_pkg::*;
#(
  parameter int N_SECT = 12,
  parameter int N_HEAD = 2,
  parameter int N_CYL  = 203,
  localparam int TOTAL  = N_SECT * N_HEAD * N_CYL,
  localparam int SECT_W = $clog2(N_SECT),
  localparam int HEAD_W = (N_HEAD > 1) ? $clog2(N_HEAD) : 1,
  localparam int CYL_W  = $clog2(N_CYL),
  localparam int LIN_W  = $clog2(TOTAL),
  localparam int CNT_W  = $clog2(TOTAL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              halt_on_err_i,
  output logic              req_o,
  output logic              cmd_o,
  output logic [CYL_W-1:0]  cyl_o,
  output logic [HEAD_W-1:0] head_o,
  output logic [SECT_W-1:0] sect_o,
  input  logic              ack_i,
  input  logic              csum_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sect_err_o,
  output logic [LIN_W-1:0]  err_idx_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  st_e  state_q;
  logic cmd_q, done_q, err_q;
  logic launch, rd_ack, rd_bad, halt_now, adv;
  logic cyl_step, last;
  logic [LIN_W-1:0] lin;

  assign launch   = (state_q == ST_IDLE) && start_i;
  assign rd_ack   = (state_q == ST_REQ) && ack_i && (cmd_q == CMD_READ);
  assign rd_bad   = rd_ack && csum_err_i;
  assign halt_now = rd_bad && halt_on_err_i;
  assign adv      = rd_ack && !halt_now && !last;

  sweep_addr_walk #(.N_SECT(N_SECT), .N_HEAD(N_HEAD), .N_CYL(N_CYL)) u_walk (
    .clk_i, .rst_ni,
    .clr_i      (launch),
    .adv_i      (adv),
    .cyl_o      (cyl_o),
    .head_o     (head_o),
    .sect_o     (sect_o),
    .lin_o      (lin),
    .cyl_step_o (cyl_step),
    .last_o     (last)
  );

  sweep_err_track #(.LIN_W(LIN_W), .CNT_W(CNT_W)) u_err (
    .clk_i, .rst_ni,
    .clr_i  (launch),
    .hit_i  (rd_bad),
    .idx_i  (lin),
    .flag_o (sect_err_o),
    .idx_o  (err_idx_o),
    .cnt_o  (err_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_SEEK;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_REQ;
          cmd_q   <= CMD_SEEK;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
        end
        ST_REQ: if (ack_i) begin
          if (cmd_q == CMD_SEEK) begin
            cmd_q   <= CMD_READ;
            state_q <= ST_GAP;
          end else if (halt_now) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (last) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cmd_q   <= cyl_step ? CMD_SEEK : CMD_READ;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: state_q <= ST_REQ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == ST_REQ);
  assign cmd_o  = cmd_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(cmd_o) && $stable(cyl_o) && $stable(head_o) && $stable(sect_o));
  p_gap_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);
  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !err_o);
  p_halt_stops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && cmd_o && csum_err_i && halt_on_err_i |=> !busy_o && err_o);
  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !ack_i |=> busy_o && $stable(cyl_o) && $stable(sect_o));
  p_seek_no_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !cmd_o |=> !sect_err_o);
endmodule

// File: tb/sim_sweep_seq.sv
module sim_sweep_seq;
  import sweep_pkg::*;
  localparam int NS = 12, NH = 2, NC = 203;

  logic clk_i = 0, rst_ni = 0, start_i = 0, halt_on_err_i = 0, ack_i = 0, csum_err_i = 0;
  logic req_o, cmd_o, busy_o, done_o, err_o, sect_err_o;
  logic [7:0] cyl_o;
  logic [0:0] head_o;
  logic [3:0] sect_o;
  logic [12:0] err_idx_o, err_cnt_o;

  sweep_seq u0 (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  bit eng_on = 0, seek_err = 0;
  int err_pct = 0, err_at = -1;
  int m_cyl, m_head, m_sect, m_reads, m_seeks, m_errs, m_lin;
  bit m_need_seek, pend, pend_err;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int lin_of(int c, int h, int s);
    return c * NH * NS + h * NS + s;
  endfunction

  // transaction engine model
  initial begin
    forever begin
      @(negedge clk_i);
      if (pend) begin
        chk(!req_o, "R5 req low after ack", req_o, 0);
        chk(sect_err_o == pend_err, "R8 sect_err pulse", sect_err_o, pend_err);
        if (pend_err) chk(err_idx_o == m_lin, "R8 err index", err_idx_o, m_lin);
        pend = 0;
      end
      ack_i = 0;
      csum_err_i = 0;
      if (eng_on && req_o) begin
        automatic int lat = $urandom % 3;
        automatic logic c0 = cmd_o;
        automatic int y0 = cyl_o, h0 = head_o, s0 = sect_o;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk_i);
          chk(req_o && cmd_o == c0 && cyl_o == y0 && head_o == h0 && sect_o == s0,
              "R5 request held", req_o, 1);
        end
        if (m_need_seek) begin
          chk(cmd_o == CMD_SEEK, "R3 seek cmd", cmd_o, CMD_SEEK);
          chk(cyl_o == m_cyl, "R3 seek cylinder", cyl_o, m_cyl);
          m_seeks++;
          m_need_seek = 0;
          ack_i = 1;
          csum_err_i = seek_err;
          pend = 1;
          pend_err = 0;
        end else begin
          automatic bit e;
          chk(cmd_o == CMD_READ, "R2 read cmd", cmd_o, CMD_READ);
          chk(lin_of(cyl_o, head_o, sect_o) == lin_of(m_cyl, m_head, m_sect), "R2 read address",
              lin_of(cyl_o, head_o, sect_o), lin_of(m_cyl, m_head, m_sect));
          e = (m_reads == err_at) || (err_pct > 0 && ($urandom % 100) < err_pct);
          m_reads++;
          ack_i = 1;
          csum_err_i = e;
          pend = 1;
          pend_err = e;
          if (e) begin
            m_errs++;
            m_lin = lin_of(m_cyl, m_head, m_sect);
          end
          if (!(e && halt_on_err_i)) begin
            m_sect++;
            if (m_sect == NS) begin
              m_sect = 0;
              m_head++;
              if (m_head == NH) begin
                m_head = 0;
                m_cyl++;
                m_need_seek = 1;
              end
            end
          end
        end
      end
    end
  end

  task automatic run(input bit halt, input int pct, input int at, input bit serr, input bit poke);
    m_cyl = 0; m_head = 0; m_sect = 0; m_reads = 0; m_seeks = 0; m_errs = 0; m_lin = 0;
    m_need_seek = 1; pend = 0;
    halt_on_err_i = halt; err_pct = pct; err_at = at; seek_err = serr; eng_on = 1;
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    chk(busy_o, "R10 busy after start", busy_o, 1);
    chk(!done_o && !err_o, "R10 status cleared by start", done_o + err_o, 0);
    begin
      int cyc = 0;
      while (busy_o) begin
        @(negedge clk_i);
        cyc++;
        start_i = (poke && cyc == 200);
      end
    end
    start_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !req_o, "R1 idle after reset", busy_o + req_o, 0);
    chk(!done_o && !err_o && !sect_err_o, "R1 status clear", done_o + err_o + sect_err_o, 0);
    chk(err_cnt_o == 0, "R1 count clear", err_cnt_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // R7 random errors ignored, start poke ignored (R10)
    run(0, 4, -1, 0, 1);
    chk(m_reads == 4872, "R4 read count", m_reads, 4872);
    chk(m_seeks == 203, "R4 seek count", m_seeks, 203);
    chk(done_o && !err_o, "R7 completes despite errors", {done_o, err_o}, 2);
    chk(err_cnt_o == m_errs, "R8 error count", err_cnt_o, m_errs);
    repeat (20) @(negedge clk_i);
    chk(done_o && !busy_o && err_cnt_o == m_errs, "R10 status holds", done_o, 1);

    // R6 halt at read 30, R9 seek errors ignored
    run(1, 0, 30, 1, 0);
    chk(m_reads == 31, "R6 reads before halt", m_reads, 31);
    chk(m_seeks == 2, "R9 seeks survive csum", m_seeks, 2);
    chk(err_o && !done_o, "R6 halt status", {done_o, err_o}, 1);
    chk(err_cnt_o == 1, "R9 only read errors counted", err_cnt_o, 1);
    repeat (10) begin
      @(negedge clk_i);
      chk(!req_o, "R6 no request after halt", req_o, 0);
    end

    // R6 halt on the very last sector
    run(1, 0, 4871, 0, 0);
    chk(m_reads == 4872, "R2 reached last sector", m_reads, 4872);
    chk(err_o && !done_o, "R6 last-sector halt wins", {done_o, err_o}, 1);
    chk(err_idx_o == lin_of(NC - 1, NH - 1, NS - 1), "R8 last index", err_idx_o, 4871);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule